// File: doc/BRIEF.md
# Cartridge Program-Bank Mapper with Cycle-Count Interrupt

This block sits on an 8-bit console's CPU bus inside a cartridge. It watches the three upper address lines, the cartridge ROM-select strobe (active low), the read/write line, three data bits and the CPU phase clock. From these it drives the three upper program-ROM address lines, an active-low ROM output enable and an active-low interrupt request.

The CPU address space above $6000 is split into five 8 KiB windows. Four of them map to fixed ROM banks. The $C000–$DFFF window maps to the bank held in a 3-bit register, which software loads by writing to the top window.

A 14-bit counter counts CPU cycles. When its top bit sets, the counter raises the interrupt and then stops. The interrupt stays asserted until software writes to the $8000 window. That write clears the counter, holds it at zero and drops the request. A write to the $A000 window lets the counter run again. Register writes are captured on the falling edge of the phase clock, by which time the strobe has settled.

Top module: `prg_irq_mapper`

## Requirements
- R1: While `rst` is held and after it is released, the bank register is 0, the counter is held at zero and `irq_n` is 1 until software releases the counter.
- R2: On reads with `cpu_a_hi` = 3'b110 ($C000–$DFFF), `prg_a` equals the bank register. A write with `cpu_a_hi` = 3'b111 ($E000–$FFFF) loads that register from `cpu_d[2:0]`.
- R3: Fixed windows map as follows on `prg_a`: `cpu_a_hi` 3'b011 ($6000) gives 6, 3'b100 ($8000) gives 4, 3'b101 ($A000) gives 5, and 3'b111 ($E000) gives 7.
- R4: On a read (`cpu_rnw` = 1), `rom_oe_n` is 0 when `rom_sel_n` is 0 or when `cpu_a_hi` = 3'b011. On any other read it is 1, for example $4000–$5FFF.
- R5: `rom_oe_n` is 1 during every write (`cpu_rnw` = 0), whatever the address.
- R6: A register write needs `rom_sel_n` = 0 and `cpu_rnw` = 0. A write with `rom_sel_n` = 1 changes no register. A write to `cpu_a_hi` = 3'b110 changes no register.
- R7: A write with `cpu_a_hi` = 3'b101 releases the counter. `irq_n` stays 1 through the 8191st rising clock edge after the capturing falling edge, and goes to 0 after the 8192nd.
- R8: Once `irq_n` is 0, it stays 0 and the counter stops, until a write with `cpu_a_hi` = 3'b100.
- R9: A write with `cpu_a_hi` = 3'b100 returns `irq_n` to 1 at the next rising edge and holds the counter at zero. While the counter is held, no interrupt is raised. A later release counts a full 8192 cycles from zero again.
- R10: Register writes take effect at the falling clock edge of the write cycle. A bank load is visible on `prg_a` before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU phase clock; counter on rising edge, register writes on falling edge |
| rst | input | 1 | Synchronous active-high power-on reset |
| cpu_d | input | 3 | CPU data bits 2..0 |
| cpu_a_hi | input | 3 | CPU address bits 15..13 |
| rom_sel_n | input | 1 | Cartridge ROM-select strobe, low for $8000–$FFFF while the clock is high |
| cpu_rnw | input | 1 | 1 = CPU read, 0 = CPU write |
| prg_a | output | 3 | Program-ROM address bits 15..13 |
| rom_oe_n | output | 1 | ROM output enable, active low |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bound checker watches several properties on every rising edge:
- the output enable stays off during writes;
- the output enable turns on for reads in the $6000 window;
- the fixed $E000 mapping holds;
- the counter advances by exactly one per cycle while it runs;
- the interrupt drops at the first edge after a hold;
- the interrupt stays asserted until it is acknowledged.

Some behaviour only the bench's scenarios can show. These are the exact 8192-cycle distance to the interrupt, the mid-cycle visibility of a bank load, and the writes that must leave the bank register untouched. The bench also shows that an acknowledge part-way through a count restarts the full count.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    localparam int BANK_W = 3;
    localparam int WIN_W  = 3;

    // 8 KiB window selected by CPU address bits 15..13
    typedef enum logic [WIN_W-1:0] {
        WIN_LO0 = 3'b000,
        WIN_LO1 = 3'b001,
        WIN_LO2 = 3'b010,
        WIN_6K  = 3'b011,
        WIN_8K  = 3'b100,
        WIN_AK  = 3'b101,
        WIN_CK  = 3'b110,
        WIN_EK  = 3'b111
    } win_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_HOLD,
        OP_RUN,
        OP_BANK
    } reg_op_e;

    typedef struct packed {
        logic              hold;
        logic [BANK_W-1:0] bank;
    } regs_t;

    localparam regs_t REGS_RESET = '{hold: 1'b1, bank: '0};

    // Which register action a qualified write to a window performs
    function automatic reg_op_e write_op(win_e w);
        case (w)
            WIN_8K:  return OP_HOLD;
            WIN_AK:  return OP_RUN;
            WIN_EK:  return OP_BANK;
            default: return OP_NONE;
        endcase
    endfunction

    // Bank tied to each non-switchable window
    function automatic logic [BANK_W-1:0] fixed_bank(win_e w);
        case (w)
            WIN_6K:  return 3'd6;
            WIN_8K:  return 3'd4;
            WIN_AK:  return 3'd5;
            WIN_EK:  return 3'd7;
            default: return {~w[2], w[1:0]};
        endcase
    endfunction

endpackage

// File: rtl/mapper_regs.sv
module mapper_regs
    import mapper_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  win_e              win,
    input  logic [BANK_W-1:0] data,
    output regs_t             q
);

    reg_op_e op;

    always_comb begin
        op = wr_en ? write_op(win) : OP_NONE;
    end

    // Captured late in the high phase, once the strobe has settled
    always_ff @(negedge clk) begin
        if (rst) begin
            q <= REGS_RESET;
        end else begin
            case (op)
                OP_HOLD: q.hold <= 1'b1;
                OP_RUN:  q.hold <= 1'b0;
                OP_BANK: q.bank <= data;
                default: q      <= q;
            endcase
        end
    end

endmodule

// File: rtl/mapper_cycle_timer.sv
module mapper_cycle_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    output logic [CNT_W-1:0] cnt,
    output logic             expired
);

    localparam int TOP = CNT_W - 1;

    always_comb begin
        expired = cnt[TOP];
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mapper_addr_mux.sv
module mapper_addr_mux
    import mapper_pkg::*;
(
    input  win_e              win,
    input  logic              rom_sel_n,
    input  logic              cpu_rnw,
    input  logic [BANK_W-1:0] bank,
    output logic [BANK_W-1:0] prg_a,
    output logic              rom_oe_n
);

    logic in_rom_space;

    always_comb begin
        in_rom_space = !rom_sel_n || (win == WIN_6K);
        rom_oe_n     = !(cpu_rnw && in_rom_space);
        prg_a        = (win == WIN_CK) ? bank : fixed_bank(win);
    end

endmodule

// File: rtl/prg_irq_mapper.sv
module prg_irq_mapper
    import mapper_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] cpu_d,
    input  logic [WIN_W-1:0]  cpu_a_hi,
    input  logic              rom_sel_n,
    input  logic              cpu_rnw,
    output logic [BANK_W-1:0] prg_a,
    output logic              rom_oe_n,
    output logic              irq_n
);

    win_e             win;
    logic             wr_en;
    regs_t            regs;
    logic             ctr_hold;
    logic [CNT_W-1:0] cnt;
    logic             expired;

    always_comb begin
        win      = win_e'(cpu_a_hi);
        wr_en    = !rom_sel_n && !cpu_rnw;
        ctr_hold = regs.hold;
        irq_n    = !expired;
    end

    mapper_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .win   (win),
        .data  (cpu_d),
        .q     (regs)
    );

    mapper_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .hold    (ctr_hold),
        .cnt     (cnt),
        .expired (expired)
    );

    mapper_addr_mux u_mux (
        .win       (win),
        .rom_sel_n (rom_sel_n),
        .cpu_rnw   (cpu_rnw),
        .bank      (regs.bank),
        .prg_a     (prg_a),
        .rom_oe_n  (rom_oe_n)
    );

endmodule

// File: rtl/mapper_chk.sv
module mapper_chk #(
    parameter int CNT_W = 14
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       cpu_a_hi,
    input logic             cpu_rnw,
    input logic [2:0]       prg_a,
    input logic             rom_oe_n,
    input logic             irq_n,
    input logic             ctr_hold,
    input logic [CNT_W-1:0] cnt
);

    localparam int TOP = CNT_W - 1;

    AST_OE_OFF_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !cpu_rnw |-> rom_oe_n); // R5

    AST_OE_ON_LOW_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (cpu_rnw && cpu_a_hi == 3'b011) |-> !rom_oe_n); // R4

    AST_TOP_WINDOW_FIXED: assert property (@(posedge clk) disable iff (rst)
        (cpu_a_hi == 3'b111) |-> (prg_a == 3'd7)); // R3

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!ctr_hold && !cnt[TOP]) |=> (cnt == $past(cnt) + 1'b1)); // R7

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && !ctr_hold) |=> !irq_n); // R8

    AST_HOLD_CLEARS_IRQ: assert property (@(posedge clk) disable iff (rst)
        ctr_hold |=> (irq_n && cnt == '0)); // R9

endmodule

bind prg_irq_mapper mapper_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cpu_a_hi (cpu_a_hi),
    .cpu_rnw  (cpu_rnw),
    .prg_a    (prg_a),
    .rom_oe_n (rom_oe_n),
    .irq_n    (irq_n),
    .ctr_hold (ctr_hold),
    .cnt      (cnt)
);

// File: tb/tb_prg_irq_mapper.sv
module tb_prg_irq_mapper;

    localparam int CLK_PERIOD = 10;
    localparam int IRQ_DIST   = 8192;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cpu_d = '0;
    logic [2:0] cpu_a_hi = '0;
    logic       rom_sel_n = 1'b1;
    logic       cpu_rnw = 1'b1;
    logic [2:0] prg_a;
    logic       rom_oe_n;
    logic       irq_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    typedef enum int {K_PRG, K_OE, K_IRQ} kind_e;
    typedef struct {
        string req;
        kind_e kind;
        int    exp;
    } item_t;

    item_t sb[$];
    event  sample_ev;

    prg_irq_mapper dut (
        .clk       (clk),
        .rst       (rst),
        .cpu_d     (cpu_d),
        .cpu_a_hi  (cpu_a_hi),
        .rom_sel_n (rom_sel_n),
        .cpu_rnw   (cpu_rnw),
        .prg_a     (prg_a),
        .rom_oe_n  (rom_oe_n),
        .irq_n     (irq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: pops expectations and compares them with the live outputs
    initial begin
        forever begin
            @(sample_ev);
            while (sb.size() > 0) begin
                item_t it;
                int    act;
                it = sb.pop_front();
                case (it.kind)
                    K_PRG:   act = int'(prg_a);
                    K_OE:    act = int'(rom_oe_n);
                    default: act = int'(irq_n);
                endcase
                n_checks++;
                if (act != it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d actual=%0d expected=%0d at %0t",
                             it.req, it.kind, act, it.exp, $time);
                end
            end
        end
    end

    task automatic expect_out(string req, kind_e k, int exp);
        item_t it;
        it.req  = req;
        it.kind = k;
        it.exp  = exp;
        sb.push_back(it);
    endtask

    task automatic flush();
        #1;
        -> sample_ev;
        #1;
    endtask

    task automatic go_idle();
        cpu_a_hi  = 3'b000;
        rom_sel_n = 1'b1;
        cpu_rnw   = 1'b1;
        cpu_d     = '0;
    endtask

    // Drives one bus cycle; returns just after its falling edge
    task automatic bus_write(logic [2:0] a, logic [2:0] d, logic sel_n);
        @(posedge clk);
        #2;
        cpu_a_hi  = a;
        cpu_d     = d;
        rom_sel_n = sel_n;
        cpu_rnw   = 1'b0;
        @(negedge clk);
        #1;
    endtask

    task automatic set_read(logic [2:0] a);
        cpu_a_hi  = a;
        rom_sel_n = ~a[2];
        cpu_rnw   = 1'b1;
    endtask

    task automatic read_check(string req, logic [2:0] a, int exp_prg, int exp_oe);
        @(posedge clk);
        #2;
        set_read(a);
        if (exp_prg >= 0) expect_out(req, K_PRG, exp_prg);
        expect_out(req, K_OE, exp_oe);
        flush();
    endtask

    task automatic irq_check(string req, int exp);
        expect_out(req, K_IRQ, exp);
        flush();
    endtask

    task automatic wait_edges(int n);
        go_idle();
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #2;
        irq_check("R1 irq high in reset", 1);
        rst = 1'b0;
        read_check("R1 bank resets to 0", 3'b110, 0, 0);
        wait_edges(9000);
        irq_check("R1 counter held after reset", 1);

        read_check("R3 $6000 bank 6", 3'b011, 6, 0);
        read_check("R3 $8000 bank 4", 3'b100, 4, 0);
        read_check("R3 $A000 bank 5", 3'b101, 5, 0);
        read_check("R3 $E000 bank 7", 3'b111, 7, 0);
        read_check("R4 $4000 oe off", 3'b010, -1, 1);
        read_check("R4 $0000 oe off", 3'b000, -1, 1);

        // R10: bank load visible right after the falling edge
        bus_write(3'b111, 3'd5, 1'b0);
        expect_out("R5 oe off during write", K_OE, 1);
        flush();
        set_read(3'b110);
        expect_out("R10 bank visible before rising edge", K_PRG, 5);
        flush();
        go_idle();

        bus_write(3'b111, 3'd2, 1'b0);
        go_idle();
        read_check("R2 $C000 follows bank 2", 3'b110, 2, 0);

        bus_write(3'b111, 3'd6, 1'b1);
        go_idle();
        read_check("R6 write without strobe ignored", 3'b110, 2, 0);
        bus_write(3'b110, 3'd7, 1'b0);
        go_idle();
        read_check("R6 write to $C000 ignored", 3'b110, 2, 0);
        wait_edges(9000);
        irq_check("R6 $C000 write leaves counter held", 1);

        // R7 exact distance
        bus_write(3'b101, 3'd0, 1'b0);
        wait_edges(IRQ_DIST - 1);
        irq_check("R7 irq still high at 8191", 1);
        @(posedge clk);
        #2;
        irq_check("R7 irq low at 8192", 0);

        wait_edges(20000);
        irq_check("R8 irq stays low", 0);
        bus_write(3'b110, 3'd1, 1'b0);
        go_idle();
        wait_edges(3);
        irq_check("R8 irq unaffected by $C000 write", 0);
        bus_write(3'b101, 3'd0, 1'b0);
        wait_edges(3);
        irq_check("R8 irq unaffected by release write", 0);

        // R9 acknowledge
        bus_write(3'b100, 3'd0, 1'b0);
        go_idle();
        @(posedge clk);
        #2;
        irq_check("R9 ack clears irq", 1);
        wait_edges(9000);
        irq_check("R9 no irq while held", 1);

        // R9 restart after mid-count acknowledge
        bus_write(3'b101, 3'd0, 1'b0);
        wait_edges(4000);
        bus_write(3'b100, 3'd0, 1'b0);
        bus_write(3'b101, 3'd0, 1'b0);
        wait_edges(IRQ_DIST - 1);
        irq_check("R9 full count after restart", 1);
        @(posedge clk);
        #2;
        irq_check("R9 irq after full restart count", 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule